// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits on the synchronous side of a design and drives an external asynchronous static RAM. Each request is a single beat: one read or one write. The RAM has active-low chip select, write enable and output enable strobes, an address bus, and separate data pins in each direction. The controller turns every request into a strobe sequence whose phases last a whole number of controller clock cycles. Each phase length is the datasheet limit in picoseconds divided by the clock period, rounded up.

The user side uses a level request with a write flag, an address and write data. The controller answers with a one-cycle acknowledge when it accepts the request. For a read, it later returns the data with a one-cycle valid strobe. Only one request is in flight at a time. Chip select goes high between transactions so that the RAM drops into standby. Output enable is held high for the whole of a write so that the RAM never drives its output while the controller is writing. Address and write data are registered when the request is accepted and held until the next acceptance.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all three strobes (chip select, write enable, output enable; all active low) are high, and acknowledge and read-valid are low.
- R2: The controller accepts a request (req_valid high, req_write=1 for a write and 0 for a read) only when it is idle. It signals acceptance with req_ack high for exactly one cycle. A request held high after its acknowledge does not start a second transaction.
- R3: For a read, chip select and output enable go low on the acceptance edge with write enable high. They stay low for RD_CYC cycles, where RD_CYC = max(ceil(tAA)+1, ceil(tRC), ceil(tOE)+1) in clock periods. With default timing and a 4 ns period this is 4.
- R4: Read data is sampled on the last edge of the read, one cycle after the address-access cycle count has elapsed. rd_valid is high for exactly one cycle, RD_CYC cycles after the acknowledge cycle.
- R5: For a write, chip select and write enable go low on the acceptance edge and output enable stays high throughout. Write enable stays low for WR_CYC = ceil(max(tWP, tAW, tCW, tDS)) cycles, which is 3 with default timing and a 4 ns period. Write enable is never low while chip select is high.
- R6: Data written to an address is returned by any later read of that address, until the address is overwritten.
- R7: Between two transactions, chip select stays high for at least GAP+1 cycles. After a read, GAP = max(ceil(tDIS), 1). After a write, GAP = max(ceil(tWR), ceil(tWC) - WR_CYC, 1).
- R8: While chip select is low, the RAM address, the RAM data-in and the write enable level do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Data for a write |
| req_ack | output | 1 | One-cycle acceptance pulse |
| rd_data | output | DATA_W | Data returned by the last read |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| sram_addr | output | ADDR_W | Address to the RAM |
| sram_din | output | DATA_W | Data to the RAM data-in pins |
| sram_dout | input | DATA_W | Data from the RAM data-out pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that the user keeps req_write, req_addr and req_wdata stable from the moment req_valid rises until req_ack is seen. They also assume that the RAM output is meaningful only after chip select and output enable have been low for the access-time cycle count. The stimulus tasks raise a request on a falling edge and hold all its fields until the acknowledge appears. The RAM model returns the inverted stored word until the access count has elapsed, so a read sampled too early returns wrong data. The sweeps cover every address of a small configuration, back-to-back requests, requests held one cycle past their acknowledge, and idle gaps of varying length.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_GAP   = 2'd3
  } ctl_state_e;

  // Smallest whole number of clock periods covering t_ps.
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned period_ps);
    return (t_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_hold.sv
module sram_ctl_hold #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic [DATA_W-1:0] pin_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample;
      if (sample) begin
        rd_data <= pin_data;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 1,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_AA_PS       = 12000,  // address access
  parameter int T_RC_PS       = 12000,  // read cycle
  parameter int T_OE_PS       = 6000,   // output enable access
  parameter int T_DIS_PS      = 6000,   // output turn-off
  parameter int T_WC_PS       = 12000,  // write cycle
  parameter int T_WP_PS       = 10000,  // write pulse, output enable high
  parameter int T_AW_PS       = 10000,  // address valid to write end
  parameter int T_CW_PS       = 10000,  // select low to write end
  parameter int T_DS_PS       = 6000,   // data setup to write end
  parameter int T_WR_PS       = 1000    // write recovery
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_din,
  input  logic [DATA_W-1:0] sram_dout,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  localparam int unsigned P       = CLK_PERIOD_PS;
  localparam int unsigned AA_CYC  = ps_to_cycles(T_AA_PS, P);
  localparam int unsigned RC_CYC  = ps_to_cycles(T_RC_PS, P);
  localparam int unsigned OE_CYC  = ps_to_cycles(T_OE_PS, P);
  localparam int unsigned DIS_CYC = ps_to_cycles(T_DIS_PS, P);
  localparam int unsigned WC_CYC  = ps_to_cycles(T_WC_PS, P);
  localparam int unsigned WR_CYC  = ps_to_cycles(T_WR_PS, P);

  // Read strobes span the access time plus one sampling cycle.
  localparam int unsigned RD_HOLD = umax(umax(AA_CYC + 1, RC_CYC), OE_CYC + 1);
  // Write enable low until pulse, address, select and data limits all hold.
  localparam int unsigned WR_HOLD = umax(1, umax(umax(ps_to_cycles(T_WP_PS, P),
                                                      ps_to_cycles(T_AW_PS, P)),
                                                 umax(ps_to_cycles(T_CW_PS, P),
                                                      ps_to_cycles(T_DS_PS, P))));
  localparam int unsigned WC_REST = (WC_CYC > WR_HOLD) ? (WC_CYC - WR_HOLD) : 0;
  localparam int unsigned RD_GAP  = umax(DIS_CYC, 1);
  localparam int unsigned WR_GAP  = umax(umax(WR_CYC, WC_REST), 1);
  localparam int unsigned CNT_MAX = umax(umax(RD_HOLD, WR_HOLD), umax(RD_GAP, WR_GAP));
  localparam int          CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  ctl_state_e       state;
  logic             expired;
  logic             accept;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             rd_sample;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign rd_sample = (state == ST_READ) && expired;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE: begin
        t_load = req_valid;
        t_val  = req_write ? CNT_W'(WR_HOLD - 1) : CNT_W'(RD_HOLD - 1);
      end
      ST_READ: begin
        t_load = expired;
        t_val  = CNT_W'(RD_GAP - 1);
      end
      ST_WRITE: begin
        t_load = expired;
        t_val  = CNT_W'(WR_GAP - 1);
      end
      default: begin
        t_load = 1'b0;
        t_val  = '0;
      end
    endcase
  end

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (expired)
  );

  sram_ctl_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (accept),
    .addr_in (req_addr),
    .data_in (req_wdata),
    .addr_q  (sram_addr),
    .data_q  (sram_din)
  );

  sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk      (clk),
    .rst      (rst),
    .sample   (rd_sample),
    .pin_data (sram_dout),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      req_ack   <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state     <= req_write ? ST_WRITE : ST_READ;
            sram_cs_n <= 1'b0;
            sram_we_n <= ~req_write;
            sram_oe_n <= req_write;
            req_ack   <= 1'b1;
          end
        end
        ST_READ: begin
          if (expired) begin
            state     <= ST_GAP;
            sram_cs_n <= 1'b1;
            sram_oe_n <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (expired) begin
            state     <= ST_GAP;
            sram_cs_n <= 1'b1;
            sram_we_n <= 1'b1;
          end
        end
        default: begin
          if (expired) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 1,
  parameter int WR_CYCS = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ack,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_din,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n
);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt <= '0;
    end else if (!sram_we_n) begin
      we_low_cnt <= we_low_cnt + 1'b1;
    end else begin
      we_low_cnt <= '0;
    end
  end

  p_strobes_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sram_cs_n && sram_we_n && sram_oe_n && !req_ack && !rd_valid));

  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (!sram_cs_n && sram_we_n));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && !sram_cs_n));

  p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_low_cnt == 16'(WR_CYCS)));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_cs_n) |=> sram_cs_n);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && !$past(sram_cs_n)) |-> ($stable(sram_addr) && $stable(sram_din)));

endmodule

bind sram_async_ctl sram_ctl_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .WR_CYCS (WR_HOLD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ack   (req_ack),
  .rd_valid  (rd_valid),
  .sram_addr (sram_addr),
  .sram_din  (sram_din),
  .sram_cs_n (sram_cs_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n)
);

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;

  localparam int AW    = 4;
  localparam int DW    = 2;
  localparam int P     = 4000;
  localparam int WORDS = 1 << AW;

  function automatic int cyc(input int t);
    return (t + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected counts derived from the requirements
  localparam int E_AA   = (12000 + P - 1) / P;
  int e_rdh, e_wrh, e_rgap, e_wgap;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ack;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_din;
  logic [DW-1:0] sram_dout;
  logic          sram_cs_n, sram_we_n, sram_oe_n;

  int checks = 0;
  int fails  = 0;
  int issued = 0;
  int cs_falls = 0;
  logic [DW-1:0] shadow [WORDS];

  always #10 clk = ~clk;

  sram_async_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(P)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
    .sram_din(sram_din), .sram_dout(sram_dout), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // RAM model: output is the inverted word until the access count elapses
  logic [DW-1:0] mem [WORDS];
  int            age = 0;
  int            wl  = 0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdat  = '0;

  always @(posedge clk) begin
    age <= (!sram_cs_n && !sram_oe_n) ? ((age < 255) ? age + 1 : age) : 0;
    if (!sram_cs_n && !sram_we_n) begin
      wl    <= wl + 1;
      waddr <= sram_addr;
      wdat  <= sram_din;
    end else if (wl != 0) begin
      mem[waddr] <= wdat;
      wl         <= 0;
    end
  end

  assign sram_dout = (age >= E_AA) ? mem[sram_addr] : ~mem[sram_addr];

  // Pin monitor
  bit            cs_prev = 1'b1;
  bit            have_prev = 1'b0;
  bit            last_wr = 1'b0;
  bit            we_at_fall = 1'b1;
  int            hi_run = 0;
  int            we_low = 0;
  int            oe_low = 0;
  logic [AW-1:0] addr_at_fall = '0;
  logic [DW-1:0] din_at_fall = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_cs_n) begin
        if (cs_prev) begin
          cs_falls++;
          if (have_prev)
            check(hi_run >= (last_wr ? e_wgap : e_rgap) + 1, "R7 select gap",
                  hi_run, (last_wr ? e_wgap : e_rgap) + 1);
          addr_at_fall = sram_addr;
          din_at_fall  = sram_din;
          we_at_fall   = sram_we_n;
          we_low = 0;
          oe_low = 0;
        end else begin
          if (sram_addr != addr_at_fall || sram_din != din_at_fall)
            check(1'b0, "R8 address/data moved", int'(sram_addr), int'(addr_at_fall));
          if (sram_we_n != we_at_fall)
            check(1'b0, "R8 write enable moved", int'(sram_we_n), int'(we_at_fall));
        end
        if (!sram_we_n) we_low++;
        if (!sram_oe_n) oe_low++;
        if (!sram_we_n && !sram_oe_n)
          check(1'b0, "R5 output enable low during write", 0, 1);
        hi_run = 0;
      end else begin
        if (!cs_prev) begin
          have_prev = 1'b1;
          last_wr   = !we_at_fall;
          if (last_wr) begin
            check(we_low == e_wrh, "R5 write pulse cycles", we_low, e_wrh);
            check(oe_low == 0, "R5 output enable stays high", oe_low, 0);
          end else begin
            check(oe_low == e_rdh, "R3 read strobe cycles", oe_low, e_rdh);
          end
        end
        if (!sram_we_n || !sram_oe_n)
          check(1'b0, "R5 strobe low without select", int'(sram_we_n), 1);
        hi_run++;
      end
      cs_prev = sram_cs_n;
    end
  end

  task automatic do_req(input bit wr, input int a, input logic [DW-1:0] d, input bit hold_extra);
    int waited;
    int k;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = d;
    waited = 0;
    while (!req_ack && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(req_ack == 1'b1, "R2 acknowledge seen", int'(req_ack), 1);
    issued++;
    if (!hold_extra) req_valid = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        check(req_ack == 1'b0, "R2 acknowledge lasts one cycle", int'(req_ack), 0);
        req_valid = 1'b0;
      end
    end while (!wr && !rd_valid && k < 64);
    if (wr) begin
      shadow[a] = d;
    end else begin
      check(k == e_rdh, "R4 acknowledge-to-valid cycles", k, e_rdh);
      check(rd_data == shadow[a], "R6 read data", int'(rd_data), int'(shadow[a]));
      @(negedge clk);
      check(rd_valid == 1'b0, "R4 valid lasts one cycle", int'(rd_valid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    e_rdh  = mx(mx(E_AA + 1, cyc(12000)), cyc(6000) + 1);
    e_wrh  = mx(mx(cyc(10000), cyc(10000)), mx(cyc(10000), cyc(6000)));
    e_rgap = mx(cyc(6000), 1);
    e_wgap = mx(mx(cyc(1000), cyc(12000) - e_wrh), 1);
    for (int i = 0; i < WORDS; i++) shadow[i] = '0;

    repeat (3) @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high in reset", 0, 1);
    check(!req_ack && !rd_valid, "R1 ack and valid low in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high after reset", 0, 1);
    check(!req_ack && !rd_valid, "R1 ack and valid low after reset", 0, 0);

    // Sweep 1: fill every word, then read every word back
    for (int a = 0; a < WORDS; a++) do_req(1'b1, a, DW'(a * 3 + 1), 1'b0);
    for (int a = 0; a < WORDS; a++) do_req(1'b0, a, '0, 1'b0);

    // Sweep 2: overwrite, read same word and a neighbour, requests held past ack
    for (int a = 0; a < WORDS; a++) begin
      do_req(1'b1, a, ~DW'(a), a[0]);
      do_req(1'b0, a, '0, a[1]);
      do_req(1'b0, (a + 7) % WORDS, '0, 1'b1);
    end

    // Sweep 3: all data values at each word with varying idle gaps
    for (int a = 0; a < WORDS; a++) begin
      for (int v = 0; v < (1 << DW); v++) begin
        repeat ((a + v) % 3) @(negedge clk);
        do_req(1'b1, a, DW'(v), 1'b0);
        repeat (v % 2) @(negedge clk);
        do_req(1'b0, a, '0, 1'b0);
      end
    end

    repeat (10) @(negedge clk);
    check(cs_falls == issued, "R2 one transaction per request", cs_falls, issued);
    check(sram_cs_n && sram_we_n && sram_oe_n, "R7 standby when idle", 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule